// File: doc/BRIEF.md
# Spread-Spectrum Differential Phase Transmit Modulator

This block is the symbol-level transmit path of a direct-sequence spread-spectrum baseband. Upstream logic supplies one bit at a time when the block asks for it. Each bit passes through a seven-stage self-synchronizing scrambler. The scrambler's feedback taps and its start state are set by configuration inputs. The scrambled bits are then differentially encoded into a two-bit carrier phase. Each symbol is sent to a downstream PN chip spreader as a phase code with a one-cycle valid pulse.

A pulse on `start_i` begins a packet. It reloads the scrambler seed, clears the phase accumulator and clears the symbol count. The first `hdr_len_i` symbols cover the preamble and header and are always sent one bit per symbol (DBPSK). After that, the data portion uses the rate chosen by `data_qpsk_i`. When that input selects DQPSK, the block changes to two bits per symbol on its own, with no external command. A symbol is started by `sym_stb_i`. The block then raises `bit_req_o` once for a DBPSK symbol, or on two consecutive cycles for a DQPSK symbol, and samples `bit_i` in each cycle in which `bit_req_o` is high.

Top module: `dsss_mod_tx`

## Requirements
- R1: While `rst_ni` is low and after it is released, `phase_o` is 0, `sym_vld_o` is 0, `qpsk_o` is 0 and `bit_req_o` is 0. No symbol is accepted until the first `start_i`.
- R2: A `start_i` pulse loads `scr_seed_i` into the scrambler, clears `phase_o` to 0 and restarts the symbol count. It takes priority over a `sym_stb_i` in the same cycle, and `sym_vld_o` is 0 in the cycle after it.
- R3: Scrambler: the output bit is `bit_i` XOR the parity of (state AND `scr_taps_i`), where tap bit k selects state stage k. The output bit is then shifted into stage 0 and every other stage moves up by one. The scrambler advances only in cycles where `bit_req_o` is high.
- R4: `phase_o` encodes the phase as a multiple of 90 degrees (0..3, wrapping). For a DBPSK symbol, a scrambled 1 adds 2 and a scrambled 0 adds 0.
- R5: For a DQPSK symbol, the first scrambled bit is the dibit MSB. The dibits 00, 01, 11 and 10 add 0, 1, 2 and 3 to the phase respectively.
- R6: The first `hdr_len_i` symbols after `start_i` are DBPSK, whatever the value of `data_qpsk_i`. When `hdr_len_i` is 0, data begins with the first symbol.
- R7: Every symbol after the header uses DQPSK when `data_qpsk_i` is 1 and DBPSK when it is 0. `qpsk_o` is 1 exactly when the symbol reported by `sym_vld_o` was a DQPSK symbol.
- R8: `bit_req_o` is high in the cycle in which a symbol strobe is accepted. For a DQPSK symbol it is also high in the following cycle. `bit_i` is sampled in each cycle in which `bit_req_o` is high.
- R9: `sym_vld_o` is a one-cycle pulse that follows the edge after the symbol's last bit request. `phase_o` changes only with that pulse or after `start_i`.
- R10: `sym_stb_i` is ignored before the first `start_i` and during the second bit cycle of a DQPSK symbol. An ignored strobe produces no extra bit request and does not advance the scrambler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Packet start pulse |
| sym_stb_i | input | 1 | Symbol strobe from the chip timing |
| bit_i | input | 1 | Serial data bit, sampled while bit_req_o is high |
| hdr_len_i | input | HDR_W (8) | Number of preamble and header symbols |
| data_qpsk_i | input | 1 | Data portion rate: 1 = DQPSK, 0 = DBPSK |
| scr_taps_i | input | 7 | Scrambler feedback tap mask |
| scr_seed_i | input | 7 | Scrambler start state |
| bit_req_o | output | 1 | Bit request to upstream |
| sym_vld_o | output | 1 | New symbol phase valid |
| phase_o | output | 2 | Carrier phase in units of 90 degrees |
| qpsk_o | output | 1 | The reported symbol was DQPSK |

## Verification
On every cycle, the assertions check the handshake shape and the phase-step rules. Each valid pulse must follow a bit request, and a DQPSK symbol must follow two of them. The phase must hold between symbols and be 0 after a start. A DBPSK symbol may change the phase only by 0 or 180 degrees. Three things can only be shown by the bench's scenarios, which run packets with random taps, seeds, header lengths and data modes: the exact phase values, which depend on the scrambler taps and seed; the symbol at which the header ends and the rate changes; and the fact that strobes given while idle or in a second bit cycle are ignored.

// File: rtl/dsss_tx_pkg.sv
package dsss_tx_pkg;
  localparam int SCR_W = 7;
  localparam int PH_W  = 2;

  typedef logic [PH_W-1:0] phase_t;

  // Gray-coded dibit to phase step in quarter turns
  function automatic phase_t dibit_step(input logic [1:0] d);
    phase_t s;
    unique case (d)
      2'b00:   s = 2'd0;
      2'b01:   s = 2'd1;
      2'b11:   s = 2'd2;
      default: s = 2'd3;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/dsss_tx_scrambler.sv
module dsss_tx_scrambler #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic [W-1:0] taps_i,
  input  logic         shift_i,
  input  logic         din_i,
  output logic         dout_o
);
  logic [W-1:0] state_q;

  assign dout_o = din_i ^ (^(state_q & taps_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= '0;
    else if (load_i)  state_q <= seed_i;
    else if (shift_i) state_q <= {state_q[W-2:0], dout_o};
  end
endmodule

// File: rtl/dsss_tx_rate_ctl.sv
module dsss_tx_rate_ctl #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sym_stb_i,
  input  logic [CNT_W-1:0] hdr_len_i,
  input  logic             data_qpsk_i,
  output logic             bit_req_o,
  output logic             cap_o,
  output logic             done_o,
  output logic             qpsk_sym_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             active_q, busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept, second, qpsk_now;

  assign accept   = active_q & ~busy_q & sym_stb_i & ~start_i;
  assign second   = busy_q & ~start_i;
  assign qpsk_now = (cnt_q >= hdr_len_i) & data_qpsk_i;

  assign bit_req_o  = accept | second;
  assign cap_o      = accept & qpsk_now;
  assign done_o     = (accept & ~qpsk_now) | second;
  assign qpsk_sym_o = busy_q | qpsk_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      busy_q   <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      busy_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (cap_o)       busy_q <= 1'b1;
      else if (second) busy_q <= 1'b0;
      // saturate: only the header boundary matters
      if (done_o && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dsss_tx_diff_enc.sv
module dsss_tx_diff_enc
  import dsss_tx_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clear_i,
  input  logic   cap_i,
  input  logic   done_i,
  input  logic   qpsk_i,
  input  logic   sbit_i,
  output phase_t phase_o,
  output logic   vld_o,
  output logic   qpsk_o
);
  logic   msb_q;
  phase_t step;

  always_comb begin
    if (qpsk_i) step = dibit_step({msb_q, sbit_i});
    else        step = {sbit_i, 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= '0;
      vld_o   <= 1'b0;
      qpsk_o  <= 1'b0;
      msb_q   <= 1'b0;
    end else if (clear_i) begin
      phase_o <= '0;
      vld_o   <= 1'b0;
      qpsk_o  <= 1'b0;
      msb_q   <= 1'b0;
    end else begin
      vld_o <= done_i;
      if (cap_i) msb_q <= sbit_i;
      if (done_i) begin
        phase_o <= phase_o + step;
        qpsk_o  <= qpsk_i;
      end
    end
  end
endmodule

// File: rtl/dsss_mod_tx.sv
module dsss_mod_tx #(
  parameter int HDR_W = 8,
  parameter int SCR_W = dsss_tx_pkg::SCR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sym_stb_i,
  input  logic             bit_i,
  input  logic [HDR_W-1:0] hdr_len_i,
  input  logic             data_qpsk_i,
  input  logic [SCR_W-1:0] scr_taps_i,
  input  logic [SCR_W-1:0] scr_seed_i,
  output logic             bit_req_o,
  output logic             sym_vld_o,
  output logic [1:0]       phase_o,
  output logic             qpsk_o
);
  logic cap, done, qpsk_sym, sbit;

  dsss_tx_rate_ctl #(.CNT_W(HDR_W)) u_rate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .sym_stb_i   (sym_stb_i),
    .hdr_len_i   (hdr_len_i),
    .data_qpsk_i (data_qpsk_i),
    .bit_req_o   (bit_req_o),
    .cap_o       (cap),
    .done_o      (done),
    .qpsk_sym_o  (qpsk_sym)
  );

  dsss_tx_scrambler #(.W(SCR_W)) u_scr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_i),
    .seed_i  (scr_seed_i),
    .taps_i  (scr_taps_i),
    .shift_i (bit_req_o),
    .din_i   (bit_i),
    .dout_o  (sbit)
  );

  dsss_tx_diff_enc u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start_i),
    .cap_i   (cap),
    .done_i  (done),
    .qpsk_i  (qpsk_sym),
    .sbit_i  (sbit),
    .phase_o (phase_o),
    .vld_o   (sym_vld_o),
    .qpsk_o  (qpsk_o)
  );
endmodule

// File: rtl/dsss_mod_tx_chk.sv
module dsss_mod_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       bit_req_o,
  input logic       sym_vld_o,
  input logic [1:0] phase_o,
  input logic       qpsk_o
);
  AST_VLD_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o |-> $past(bit_req_o));  // R9

  AST_QPSK_TWO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_vld_o && qpsk_o) |-> ($past(bit_req_o) && $past(bit_req_o, 2)));  // R8

  AST_START_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (phase_o == 2'd0 && !sym_vld_o));  // R2

  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sym_vld_o && !$past(start_i)) |-> $stable(phase_o));  // R9

  AST_DBPSK_HALF_TURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_vld_o && !qpsk_o && !$past(start_i)) |-> (phase_o[0] == $past(phase_o[0])));  // R4

  AST_VLD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o |=> (!sym_vld_o || $past(bit_req_o)));  // R9
endmodule

bind dsss_mod_tx dsss_mod_tx_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .bit_req_o (bit_req_o),
  .sym_vld_o (sym_vld_o),
  .phase_o   (phase_o),
  .qpsk_o    (qpsk_o)
);

// File: tb/dsss_mod_tx_bench.sv
module dsss_mod_tx_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0, sym_stb_i = 1'b0, bit_i = 1'b0, data_qpsk_i = 1'b0;
  logic [7:0] hdr_len_i = '0;
  logic [6:0] scr_taps_i = '0, scr_seed_i = '0;
  logic       bit_req_o, sym_vld_o, qpsk_o;
  logic [1:0] phase_o;

  int n_chk = 0, n_fail = 0;
  logic [6:0] m_scr;
  logic [1:0] m_ph;
  int         m_cnt;

  always #4 clk_i = ~clk_i;

  dsss_mod_tx u_dsss_mod_tx (.*);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic scr_step(input logic b, output logic o);
    o = b ^ (^(m_scr & scr_taps_i));
    m_scr = {m_scr[5:0], o};
  endtask

  function automatic logic [1:0] gray_step(input logic [1:0] d);
    case (d)
      2'b00: return 2'd0;
      2'b01: return 2'd1;
      2'b11: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  task automatic do_start();
    start_i = 1'b1;
    sym_stb_i = $urandom_range(0, 1);  // R2: start wins over strobe
    @(negedge clk_i);
    start_i = 1'b0; sym_stb_i = 1'b0;
    m_scr = scr_seed_i; m_ph = 2'd0; m_cnt = 0;
    #1;
    chk(phase_o == 2'd0 && !sym_vld_o, "R2 start clear", phase_o, 0);
  endtask

  // called at a negedge (+1); ends at a negedge (+1)
  task automatic send_sym(input logic b0, input logic b1, input logic hold, input logic gap);
    logic qp, s0, s1;
    qp = (m_cnt >= int'(hdr_len_i)) && data_qpsk_i;
    sym_stb_i = 1'b1; bit_i = b0;
    #1;
    chk(bit_req_o, "R8 first request", bit_req_o, 1);
    scr_step(b0, s0);
    @(negedge clk_i);
    if (qp) begin
      sym_stb_i = hold; bit_i = b1;  // R10: strobe held in second cycle
      #1;
      chk(bit_req_o, "R8 second request", bit_req_o, 1);
      scr_step(b1, s1);
      m_ph = m_ph + gray_step({s0, s1});
      @(negedge clk_i);
    end else begin
      m_ph = m_ph + (s0 ? 2'd2 : 2'd0);
    end
    sym_stb_i = 1'b0;
    #1;
    m_cnt++;
    chk(sym_vld_o, "R9 valid pulse", sym_vld_o, 1);
    chk(phase_o == m_ph, qp ? "R5 dqpsk phase" : "R4 dbpsk phase", phase_o, m_ph);
    chk(qpsk_o == qp, m_cnt <= int'(hdr_len_i) ? "R6 header rate" : "R7 data rate", qpsk_o, qp);
    if (gap) begin
      @(negedge clk_i); #1;
      chk(!sym_vld_o && phase_o == m_ph, "R9 hold between symbols", phase_o, m_ph);
      chk(!bit_req_o, "R10 no extra request", bit_req_o, 0);
    end
  endtask

  task automatic run_pkt(input int hl, input logic q, input int nsym, input logic [6:0] taps,
                         input logic [6:0] seed);
    hdr_len_i = 8'(hl); data_qpsk_i = q; scr_taps_i = taps; scr_seed_i = seed;
    do_start();
    for (int i = 0; i < nsym; i++)
      send_sym($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
               $urandom_range(0, 3) == 0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    #1;
    chk(phase_o == 0 && !sym_vld_o && !qpsk_o && !bit_req_o, "R1 reset state", phase_o, 0);
    @(negedge clk_i); #1;
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    // R10: strobe before any start ignored
    sym_stb_i = 1'b1; #1;
    chk(!bit_req_o, "R10 idle strobe", bit_req_o, 0);
    @(negedge clk_i); sym_stb_i = 1'b0; #1;
    chk(!sym_vld_o && phase_o == 0, "R1 idle no symbol", sym_vld_o, 0);

    // R3: identity scrambler, plain DBPSK: bit 1 gives 180 degrees
    run_pkt(3, 1'b0, 3, 7'h00, 7'h00);
    // R3 taps used with seed
    run_pkt(2, 1'b1, 8, 7'h48, 7'h7f);
    // R6: header length 0, data from first symbol
    run_pkt(0, 1'b1, 6, 7'h09, 7'h15);
    // R7: data DBPSK beyond header
    run_pkt(4, 1'b0, 8, 7'h44, 7'h3a);
    for (int p = 0; p < 40; p++)
      run_pkt($urandom_range(0, 6), $urandom_range(0, 1), $urandom_range(4, 14),
              7'($urandom), 7'($urandom));
    // R2: restart mid-packet clears phase
    run_pkt(1, 1'b1, 5, 7'h48, 7'h01);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule